// File: doc/BRIEF.md
# Configurable Slice Register Bank

This block models eight one-bit storage cells that run under a single control set: one clock, one active-high clock enable and one active-high set/reset. Each cell has two stored constants of its own. One is the value that set/reset drives it to. The other is the power-up value, which an asynchronous global reset input also reloads. Parameters choose whether set/reset acts at the active clock edge or at once, and whether the clock is inverted where it enters the bank.

The cells fall into two groups of four. The lower group (`qout[3:0]`) may be built, as a whole, either as edge-triggered flip-flops or as level-sensitive latches. The upper group (`qout[7:4]`) can only be flip-flops. When the lower group is built as latches, the upper group is out of service. Its outputs then stay at their power-up values whatever arrives on data, enable or set/reset.

Top module: `srb_slice_bank`

## Requirements
- R1: While `glob_rst` is high, every bit of `qout` equals the matching bit of `INIT_VAL`, with no clock edge needed. This overrides set/reset and enable, and the same value is present at power-up.
- R2: With `SR_KIND = SR_SYNC`, `set_rst` high at an active clock edge loads `RESET_VAL` into every flip-flop, even when `clk_en` is low. Raising `set_rst` between edges leaves `qout` unchanged.
- R3: With `SR_KIND = SR_ASYNC`, raising `set_rst` forces `RESET_VAL` onto every working cell at once, and holds it there while `set_rst` stays high, across active edges.
- R4: A flip-flop with `clk_en` high and `set_rst` low loads its `din` bit at the active clock edge.
- R5: A flip-flop with `clk_en` low and `set_rst` low keeps its value across active clock edges.
- R6: With `CLK_INVERT = 0`, the active edge is the rising edge of `clk` and a latch is open while `clk` is high. With `CLK_INVERT = 1`, the active edge is the falling edge and a latch is open while `clk` is low.
- R7: With `GROUP_MODE = GRP_LATCH`, `qout[3:0]` follows `din[3:0]` while the clock is at its open level and `clk_en` is high. It holds at all other times.
- R8: With `GROUP_MODE = GRP_LATCH`, `qout[7:4]` stays equal to `INIT_VAL[7:4]` and ignores `din`, `clk_en` and `set_rst`.
- R9: With `GROUP_MODE = GRP_FLOP`, all eight bits behave as flip-flops, including the lower group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, inverted inside the bank when `CLK_INVERT` is set |
| clk_en | input | 1 | Shared clock enable, active high |
| set_rst | input | 1 | Shared set/reset to `RESET_VAL`, active high |
| glob_rst | input | 1 | Global reset to `INIT_VAL`, asynchronous, active high |
| din | input | 8 | One data bit per cell |
| qout | output | 8 | One stored bit per cell |

## Verification
Three copies of the bank are driven. The first has rising-edge flip-flops and synchronous set/reset. Its vectors alternate enable and set/reset with data patterns whose bits differ from both stored constants. This tells a load apart from a hold, and a reset apart from a reload to the power-up value. The second copy runs as latches with an inverted clock and asynchronous set/reset. It shows transparency in the low clock phase, holding in the high phase, and the frozen upper group. The third copy runs as inverted-clock flip-flops with asynchronous set/reset. Its checks confirm that the rising edge is ignored and that set/reset acts between edges.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic { GRP_FLOP = 1'b0, GRP_LATCH = 1'b1 } grp_mode_e;
  typedef enum logic { SR_SYNC  = 1'b0, SR_ASYNC  = 1'b1 } sr_kind_e;
endpackage

// File: rtl/srb_ff_cell.sv
module srb_ff_cell #(
  parameter bit INIT_BIT = 1'b0,
  parameter bit RST_BIT  = 1'b0,
  parameter bit ASYNC_SR = 1'b0
) (
  input  logic eclk,
  input  logic ce,
  input  logic sr,
  input  logic grst,
  input  logic d,
  output logic q
);
  logic q_r = INIT_BIT;

  generate
    if (ASYNC_SR) begin : g_async
      always_ff @(posedge eclk or posedge grst or posedge sr) begin
        if (grst)    q_r <= INIT_BIT;
        else if (sr) q_r <= RST_BIT;
        else if (ce) q_r <= d;
      end
    end else begin : g_sync
      always_ff @(posedge eclk or posedge grst) begin
        if (grst)    q_r <= INIT_BIT;
        else if (sr) q_r <= RST_BIT;
        else if (ce) q_r <= d;
      end
    end
  endgenerate

  assign q = q_r;
endmodule

// File: rtl/srb_latch_cell.sv
module srb_latch_cell #(
  parameter bit INIT_BIT = 1'b0,
  parameter bit RST_BIT  = 1'b0,
  parameter bit ASYNC_SR = 1'b0
) (
  input  logic eclk,
  input  logic ce,
  input  logic sr,
  input  logic grst,
  input  logic d,
  output logic q
);
  logic q_r = INIT_BIT;
  logic sr_hit;

  // synchronous flavour only lets set/reset through while the gate is open
  assign sr_hit = sr & (ASYNC_SR | eclk);

  always_latch begin
    if (grst)             q_r <= INIT_BIT;
    else if (sr_hit)      q_r <= RST_BIT;
    else if (eclk && ce)  q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/srb_frozen_cell.sv
module srb_frozen_cell #(
  parameter bit INIT_BIT = 1'b0
) (
  output logic q
);
  assign q = INIT_BIT;
endmodule

// File: rtl/srb_slice_bank.sv
module srb_slice_bank
  import srb_pkg::*;
#(
  parameter int        NUM_LATCHABLE = 4,
  parameter int        NUM_FF_ONLY   = 4,
  parameter grp_mode_e GROUP_MODE    = GRP_FLOP,
  parameter sr_kind_e  SR_KIND       = SR_SYNC,
  parameter bit        CLK_INVERT    = 1'b0,
  parameter logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0] RESET_VAL = 8'hA5,
  parameter logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0] INIT_VAL  = 8'h3C
) (
  input  logic                                   clk,
  input  logic                                   clk_en,
  input  logic                                   set_rst,
  input  logic                                   glob_rst,
  input  logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0]   din,
  output logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0]   qout
);
  localparam int  NUM_CELLS = NUM_LATCHABLE + NUM_FF_ONLY;
  localparam bit  IS_ASYNC  = (SR_KIND == SR_ASYNC);
  localparam bit  IS_LATCH  = (GROUP_MODE == GRP_LATCH);

  logic eclk;
  assign eclk = clk ^ CLK_INVERT;

  generate
    for (genvar i = 0; i < NUM_LATCHABLE; i++) begin : g_lat_grp
      if (IS_LATCH) begin : g_latch
        srb_latch_cell #(.INIT_BIT(INIT_VAL[i]), .RST_BIT(RESET_VAL[i]), .ASYNC_SR(IS_ASYNC)) u_cell (
          .eclk(eclk), .ce(clk_en), .sr(set_rst), .grst(glob_rst), .d(din[i]), .q(qout[i]));
      end else begin : g_flop
        srb_ff_cell #(.INIT_BIT(INIT_VAL[i]), .RST_BIT(RESET_VAL[i]), .ASYNC_SR(IS_ASYNC)) u_cell (
          .eclk(eclk), .ce(clk_en), .sr(set_rst), .grst(glob_rst), .d(din[i]), .q(qout[i]));
      end
    end

    for (genvar j = NUM_LATCHABLE; j < NUM_CELLS; j++) begin : g_ff_grp
      if (IS_LATCH) begin : g_off
        srb_frozen_cell #(.INIT_BIT(INIT_VAL[j])) u_cell (.q(qout[j]));
      end else begin : g_flop
        srb_ff_cell #(.INIT_BIT(INIT_VAL[j]), .RST_BIT(RESET_VAL[j]), .ASYNC_SR(IS_ASYNC)) u_cell (
          .eclk(eclk), .ce(clk_en), .sr(set_rst), .grst(glob_rst), .d(din[j]), .q(qout[j]));
      end
    end
  endgenerate
endmodule

// File: rtl/srb_checker.sv
module srb_checker
  import srb_pkg::*;
#(
  parameter int        NUM_LATCHABLE = 4,
  parameter int        NUM_FF_ONLY   = 4,
  parameter grp_mode_e GROUP_MODE    = GRP_FLOP,
  parameter sr_kind_e  SR_KIND       = SR_SYNC,
  parameter bit        CLK_INVERT    = 1'b0,
  parameter logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0] RESET_VAL = 8'hA5,
  parameter logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0] INIT_VAL  = 8'h3C
) (
  input logic                                 clk,
  input logic                                 clk_en,
  input logic                                 set_rst,
  input logic                                 glob_rst,
  input logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0] din,
  input logic [NUM_LATCHABLE+NUM_FF_ONLY-1:0] qout
);
  localparam int NT = NUM_LATCHABLE + NUM_FF_ONLY;
  localparam int NL = NUM_LATCHABLE;

  logic eclk;
  assign eclk = clk ^ CLK_INVERT;

  assert_gsr_init_R1: assert property (@(posedge eclk) glob_rst |-> qout == INIT_VAL);

  generate
    if (GROUP_MODE == GRP_FLOP) begin : g_flop_chk
      if (SR_KIND == SR_SYNC) begin : g_sync
        assert_sync_reset_R2: assert property (@(posedge eclk) disable iff (glob_rst)
          set_rst |=> qout == RESET_VAL);
        assert_load_R4: assert property (@(posedge eclk) disable iff (glob_rst)
          (!set_rst && clk_en) |=> qout == $past(din));
        assert_hold_R5: assert property (@(posedge eclk) disable iff (glob_rst)
          (!set_rst && !clk_en) |=> $stable(qout));
      end else begin : g_async
        assert_async_reset_R3: assert property (@(posedge eclk) disable iff (glob_rst)
          set_rst |-> qout == RESET_VAL);
      end
    end else begin : g_latch_chk
      assert_frozen_upper_R8: assert property (@(posedge eclk) disable iff (glob_rst)
        qout[NT-1:NL] == INIT_VAL[NT-1:NL]);
      assert_transparent_R7: assert property (@(negedge eclk) disable iff (glob_rst)
        (clk_en && !set_rst) |-> qout[NL-1:0] == din[NL-1:0]);
    end
  endgenerate
endmodule

bind srb_slice_bank srb_checker #(
  .NUM_LATCHABLE(NUM_LATCHABLE), .NUM_FF_ONLY(NUM_FF_ONLY), .GROUP_MODE(GROUP_MODE),
  .SR_KIND(SR_KIND), .CLK_INVERT(CLK_INVERT), .RESET_VAL(RESET_VAL), .INIT_VAL(INIT_VAL)
) u_chk (
  .clk(clk), .clk_en(clk_en), .set_rst(set_rst), .glob_rst(glob_rst), .din(din), .qout(qout)
);

// File: tb/sim_srb_slice_bank.sv
module sim_srb_slice_bank;
  import srb_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       ce0 = 0, sr0 = 0, g0 = 1;  logic [7:0] d0 = 0; logic [7:0] q0;
  logic       ce1 = 0, sr1 = 0, g1 = 1;  logic [7:0] d1 = 0; logic [7:0] q1;
  logic       ce2 = 0, sr2 = 0, g2 = 1;  logic [7:0] d2 = 0; logic [7:0] q2;

  // rising-edge flops, synchronous set/reset, RESET 8'hA5, INIT 8'h3C
  srb_slice_bank u0 (.clk(clk), .clk_en(ce0), .set_rst(sr0), .glob_rst(g0), .din(d0), .qout(q0));

  // latch mode, asynchronous set/reset, inverted clock, RESET 8'h5A, INIT 8'h96
  srb_slice_bank #(.GROUP_MODE(GRP_LATCH), .SR_KIND(SR_ASYNC), .CLK_INVERT(1'b1),
                   .RESET_VAL(8'h5A), .INIT_VAL(8'h96))
    u1 (.clk(clk), .clk_en(ce1), .set_rst(sr1), .glob_rst(g1), .din(d1), .qout(q1));

  // flop mode, asynchronous set/reset, inverted clock, RESET 8'hA5, INIT 8'h3C
  srb_slice_bank #(.SR_KIND(SR_ASYNC), .CLK_INVERT(1'b1))
    u2 (.clk(clk), .clk_en(ce2), .set_rst(sr2), .glob_rst(g2), .din(d2), .qout(q2));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] d;
    logic       ce;
    logic       sr;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'hF0, 1'b1, 1'b0, 8'hF0},   // R4 load
    '{8'h0F, 1'b0, 1'b0, 8'hF0},   // R5 hold
    '{8'h0F, 1'b1, 1'b0, 8'h0F},   // R4 load
    '{8'hFF, 1'b0, 1'b1, 8'hA5},   // R2 reset beats enable low
    '{8'hFF, 1'b1, 1'b1, 8'hA5},   // R2 reset beats load
    '{8'h5A, 1'b1, 1'b0, 8'h5A},   // R4
    '{8'h00, 1'b0, 1'b0, 8'h5A},   // R5
    '{8'h00, 1'b1, 1'b0, 8'h00},   // R9 all bits clear
    '{8'hFF, 1'b1, 1'b0, 8'hFF}    // R9 all bits set
  };

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 u0 global reset", q0, 8'h3C);
    chk("R1 u1 global reset", q1, 8'h96);
    chk("R1 u2 global reset", q2, 8'h3C);
    @(negedge clk); #1;
    g0 = 0; g1 = 0; g2 = 0;

    // table walk on u0
    for (int k = 0; k < NV; k++) begin
      @(negedge clk); #1;
      d0 = VECS[k].d; ce0 = VECS[k].ce; sr0 = VECS[k].sr;
      @(posedge clk); #1;
      chk($sformatf("R4/R5/R2/R9 vector %0d", k), q0, VECS[k].exp);
    end

    // R2: synchronous reset waits for the edge
    @(negedge clk); #1;
    ce0 = 0; sr0 = 1;
    #1 chk("R2 no effect before edge", q0, 8'hFF);
    @(posedge clk); #1;
    chk("R2 reset at edge", q0, 8'hA5);

    // R1: global reset acts at once and beats enable
    @(negedge clk); #1;
    sr0 = 0; ce0 = 1; d0 = 8'h77; g0 = 1;
    #1 chk("R1 async global reset", q0, 8'h3C);
    @(posedge clk); #1;
    chk("R1 global reset beats enable", q0, 8'h3C);
    @(negedge clk); #1;
    g0 = 0;
    @(posedge clk); #1;
    chk("R4 load after global reset", q0, 8'h77);
    ce0 = 0;

    // u1: latches open while clk low (R6, R7), upper group frozen (R8)
    @(negedge clk); #1;
    ce1 = 1; d1 = 8'hFF;
    #1 chk("R7 R8 transparent low group", q1, 8'h9F);
    @(posedge clk); #1;
    d1 = 8'h00; ce1 = 0;
    #1 chk("R6 R7 closed while clk high", q1, 8'h9F);
    @(negedge clk); #1;
    chk("R7 enable low holds", q1, 8'h9F);
    ce1 = 1;
    #1 chk("R7 R8 follows data", q1, 8'h90);
    @(posedge clk); #1;
    sr1 = 1;
    #1 chk("R3 R8 async reset on latches", q1, 8'h9A);
    sr1 = 0; ce1 = 0;

    // u2: falling-edge flops, asynchronous reset
    @(negedge clk); #1;
    d2 = 8'h11; ce2 = 1;
    @(posedge clk); #1;
    chk("R6 rising edge ignored", q2, 8'h3C);
    @(negedge clk); #1;
    chk("R6 R4 falling edge loads", q2, 8'h11);
    d2 = 8'h22;
    @(posedge clk); #1;
    sr2 = 1;
    #1 chk("R3 reset without edge", q2, 8'hA5);
    @(negedge clk); #1;
    chk("R3 reset held across edge", q2, 8'hA5);
    sr2 = 0;
    @(negedge clk); #1;
    chk("R4 load after reset release", q2, 8'h22);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule